// File: doc/BRIEF.md
# Bus-Mapped Watchdog Timer with Reset Cause Log

The watchdog is a 24-bit down-counter behind an APB slave port. Software loads a count, sets the enable bit, and reloads the count often enough to keep it above zero. Each pulse on the microsecond tick input lowers the count by one. The tick at which the count would pass from 1 to 0 raises a one-cycle reset request toward the chip's reset controller. Software can also request a reset at once by writing the trigger bit.

Counting stops while the block is disabled. It can also be held off while either processor is halted in debug, or while a JTAG master owns the bus; each of these three conditions has its own gate bit. A small cause register records whether the last request came from expiry, from the trigger, or from both in the same cycle. A debugger warm reset of either core clears this register. Eight scratch words and the cause register keep their contents through the chip's soft reset, and only the hard reset clears them.

Top module: `wdog_apb`

## Requirements
- R1: After hard reset, the control word at offset 0x00 reads 0x07000000: bit 30 (enable) is 0, and bits 26, 25 and 24 (pause gates) are 1. The cause register reads 0, every scratch word reads 0, and `wdog_reset_req_o` is low.
- R2: A write to offset 0x04 loads bits 23:0 of the write data into the count. Control bits 23:0 read back the remaining count. Offset 0x04 reads as 0.
- R3: While control bit 30 is 1, each `tick_us_i` pulse lowers a nonzero count by one. While bit 30 is 0, the count holds its value.
- R4: Decrementing is blocked when control bit 26 is set and `dbg_halt1_i` is high, when bit 25 is set and `dbg_halt0_i` is high, or when bit 24 is set and `jtag_active_i` is high. A halt input whose gate bit is 0 has no effect.
- R5: A tick that finds the count at 1 sets it to 0. `wdog_reset_req_o` then goes high for exactly one cycle, starting on the clock edge of that tick. A count of 0 neither decrements nor raises a further request.
- R6: A write with control bit 31 set raises `wdog_reset_req_o` for one cycle, starting on the edge of the APB access phase, and clears the count. Bit 31 always reads 0.
- R7: The cause register at offset 0x08 is rewritten at every request: bit 0 is set for expiry and bit 1 for the trigger. If both occur in the same cycle, it reads 3 and only a single one-cycle request is issued.
- R8: A pulse on `dbg_warm_rst_i` clears the cause register. A request captured in the same cycle takes precedence.
- R9: Eight 32-bit scratch words at offsets 0x0C + 4k (k = 0..7) are read/write. They keep their values through a soft reset and are cleared by a hard reset.
- R10: A synchronous soft reset (`soft_rst_ni` low) sets the control word back to 0x07000000 and the count to 0. It leaves the cause register unchanged.
- R11: Reads of unmapped or misaligned offsets return 0. `pslverr_o` is always 0 and `pready_o` always 1. Writes to offset 0x08 and to control bits 23:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | APB clock |
| rst_ni | input | 1 | Hard reset, asynchronous, active low |
| soft_rst_ni | input | 1 | Soft reset, synchronous, active low |
| dbg_warm_rst_i | input | 1 | Debugger warm reset of a core, clears the cause log |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error, tied low |
| tick_us_i | input | 1 | One-cycle microsecond tick |
| dbg_halt0_i | input | 1 | Processor 0 halted in debug |
| dbg_halt1_i | input | 1 | Processor 1 halted in debug |
| jtag_active_i | input | 1 | JTAG master using the bus |
| wdog_reset_req_o | output | 1 | One-cycle reset request |

## Verification
Expiry and the software trigger can fall in the same clock cycle. To provoke this, the bench loads a count of 1, enables the block, and then drives the tick pulse during the APB access phase of a write that sets the trigger bit. The result passes only if exactly one request cycle is counted on the output, the cause register then reads 3, and the count reads 0.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W       = 32;
  localparam int BIT_TRIG     = 31;
  localparam int BIT_EN       = 30;
  localparam int BIT_P_DBG1   = 26;
  localparam int BIT_P_DBG0   = 25;
  localparam int BIT_P_JTAG   = 24;
  localparam int WORD_CTRL    = 0;
  localparam int WORD_LOAD    = 1;
  localparam int WORD_CAUSE   = 2;
  localparam int WORD_SCR0    = 3;

  typedef struct packed {
    logic en;
    logic p_dbg1;
    logic p_dbg0;
    logic p_jtag;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{en: 1'b0, p_dbg1: 1'b1, p_dbg0: 1'b1, p_jtag: 1'b1};
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int N_SCRATCH = 8,
  parameter int CNT_W     = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [1:0]        cause_i,
  output ctrl_t             ctrl_o,
  output logic              load_we_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              force_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic              aligned;
  logic [IDX_W-1:0]  idx;
  logic              wr_en;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] scr_q [N_SCRATCH];

  assign aligned = (paddr_i[1:0] == 2'b00);
  assign idx     = paddr_i[ADDR_W-1:2];
  assign wr_en   = psel_i && penable_i && pwrite_i && aligned;

  assign ctrl_o     = ctrl_q;
  assign load_we_o  = wr_en && (idx == IDX_W'(WORD_LOAD));
  assign load_val_o = pwdata_i[CNT_W-1:0];
  assign force_o    = wr_en && (idx == IDX_W'(WORD_CTRL)) && pwdata_i[BIT_TRIG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (!soft_rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_en && (idx == IDX_W'(WORD_CTRL))) begin
      ctrl_q.en     <= pwdata_i[BIT_EN];
      ctrl_q.p_dbg1 <= pwdata_i[BIT_P_DBG1];
      ctrl_q.p_dbg0 <= pwdata_i[BIT_P_DBG0];
      ctrl_q.p_jtag <= pwdata_i[BIT_P_JTAG];
    end
  end

  // scratch survives soft reset
  for (genvar g = 0; g < N_SCRATCH; g++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scr_q[g] <= '0;
      end else if (wr_en && (idx == IDX_W'(WORD_SCR0 + g))) begin
        scr_q[g] <= pwdata_i;
      end
    end
  end

  always_comb begin
    prdata_o = '0;
    if (aligned) begin
      if (idx == IDX_W'(WORD_CTRL)) begin
        prdata_o[BIT_EN]      = ctrl_q.en;
        prdata_o[BIT_P_DBG1]  = ctrl_q.p_dbg1;
        prdata_o[BIT_P_DBG0]  = ctrl_q.p_dbg0;
        prdata_o[BIT_P_JTAG]  = ctrl_q.p_jtag;
        prdata_o[CNT_W-1:0]   = count_i;
      end else if (idx == IDX_W'(WORD_CAUSE)) begin
        prdata_o[1:0] = cause_i;
      end
      for (int k = 0; k < N_SCRATCH; k++) begin
        if (idx == IDX_W'(WORD_SCR0 + k)) prdata_o = scr_q[k];
      end
    end
  end

  // R9: scratch untouched by soft reset
  p_scratch_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_ni && !wr_en) |=> $stable(scr_q[0]));
  p_scratch_keep_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_ni && !wr_en) |=> $stable(scr_q[N_SCRATCH-1]));
  // R10: soft reset restores control defaults
  p_soft_ctrl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_ni |=> (ctrl_q == CTRL_RST));
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_ni,
  input  logic             tick_i,
  input  ctrl_t            ctrl_i,
  input  logic             dbg_halt0_i,
  input  logic             dbg_halt1_i,
  input  logic             jtag_active_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             force_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;
  logic             blocked;
  logic             step;

  assign blocked = (ctrl_i.p_dbg1 && dbg_halt1_i) ||
                   (ctrl_i.p_dbg0 && dbg_halt0_i) ||
                   (ctrl_i.p_jtag && jtag_active_i);
  assign step     = tick_i && ctrl_i.en && !blocked && (cnt_q != '0);
  assign expire_o = step && (cnt_q == CNT_W'(1));
  assign count_o  = cnt_q;
  assign req_o    = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (!soft_rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= expire_o || force_i;
      if (force_i)        cnt_q <= '0;
      else if (load_we_i) cnt_q <= load_val_i;
      else if (step)      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R3: disabled counter holds
  p_hold_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_ni && !ctrl_i.en && !load_we_i && !force_i) |=> $stable(cnt_q));
  // R4: gated pause holds
  p_hold_paused_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_ni && blocked && !load_we_i && !force_i) |=> $stable(cnt_q));
  // R5: no wrap below zero
  p_no_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_we_i) |=> (cnt_q == '0));
  // R5/R6: request is a single-cycle pulse
  p_req_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  // R6: trigger clears the count
  p_force_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_ni && force_i) |=> (cnt_q == '0 && req_q));
endmodule

// File: rtl/wdog_cause.sv
module wdog_cause (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_ni,
  input  logic       warm_i,
  input  logic       expire_i,
  input  logic       force_i,
  output logic [1:0] cause_o
);
  logic [1:0] cause_q;
  logic       capture;

  assign capture = soft_rst_ni && (expire_i || force_i);
  assign cause_o = cause_q;

  // hard reset only; capture outranks warm clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cause_q <= 2'b00;
    else if (capture) cause_q <= {force_i, expire_i};
    else if (warm_i)  cause_q <= 2'b00;
  end

  p_cause_expire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_ni && expire_i) |=> cause_q[0]);
  p_cause_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_ni && force_i) |=> cause_q[1]);
  p_warm_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_i && !capture) |=> (cause_q == 2'b00));
  p_soft_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_ni && !warm_i) |=> $stable(cause_q));
endmodule

// File: rtl/wdog_apb.sv
module wdog_apb
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int N_SCRATCH = 8,
  parameter int CNT_W     = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_ni,
  input  logic              dbg_warm_rst_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              tick_us_i,
  input  logic              dbg_halt0_i,
  input  logic              dbg_halt1_i,
  input  logic              jtag_active_i,
  output logic              wdog_reset_req_o
);
  ctrl_t            ctrl;
  logic             load_we;
  logic [CNT_W-1:0] load_val;
  logic             force_req;
  logic [CNT_W-1:0] count;
  logic             expire;
  logic [1:0]       cause;

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  wdog_regs #(.ADDR_W(ADDR_W), .N_SCRATCH(N_SCRATCH), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .soft_rst_ni,
    .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i, .prdata_o,
    .count_i(count), .cause_i(cause), .ctrl_o(ctrl),
    .load_we_o(load_we), .load_val_o(load_val), .force_o(force_req)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk_i, .rst_ni, .soft_rst_ni,
    .tick_i(tick_us_i), .ctrl_i(ctrl),
    .dbg_halt0_i, .dbg_halt1_i, .jtag_active_i,
    .load_we_i(load_we), .load_val_i(load_val), .force_i(force_req),
    .count_o(count), .expire_o(expire), .req_o(wdog_reset_req_o)
  );

  wdog_cause u_cause (
    .clk_i, .rst_ni, .soft_rst_ni,
    .warm_i(dbg_warm_rst_i), .expire_i(expire), .force_i(force_req),
    .cause_o(cause)
  );

  // R11: bus never stalls or errors
  p_bus_ok_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o && !pslverr_o);
endmodule

// File: tb/tb_wdog_apb.sv
`timescale 1ns/1ps
module tb_wdog_apb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst_n = 1'b1;
  logic        warm = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        tick = 1'b0, halt0 = 1'b0, halt1 = 1'b0, jtag = 1'b0;
  logic        req;

  int nchk = 0, nfail = 0, req_cnt = 0;

  always #2.5 clk = ~clk;

  wdog_apb dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_ni(soft_rst_n), .dbg_warm_rst_i(warm),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite), .paddr_i(paddr),
    .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
    .tick_us_i(tick), .dbg_halt0_i(halt0), .dbg_halt1_i(halt1),
    .jtag_active_i(jtag), .wdog_reset_req_o(req)
  );

  always @(negedge clk) if (rst_n && req) req_cnt++;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1; tick = tk;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; tick = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic hard_reset();
    @(negedge clk); rst_n = 0;
    idle(2); rst_n = 1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    apb_rd(8'h00, d); check("R1 ctrl", d, 32'h0700_0000);
    apb_rd(8'h08, d); check("R1 cause", d, 0);
    apb_rd(8'h0C, d); check("R1 scratch0", d, 0);
    check("R1 req", {31'd0, req}, 0);
  endtask

  task automatic t_expire();
    logic [31:0] d; int c0;
    apb_wr(8'h04, 32'hFF00_0005, 0);
    apb_wr(8'h00, 32'h4700_0000, 0);
    apb_rd(8'h04, d); check("R2 load reads zero", d, 0);
    ticks(3);
    apb_rd(8'h00, d); check("R3 count after 3 ticks", d, 32'h4700_0002);
    c0 = req_cnt;
    ticks(2); idle(2);
    check("R5 one request cycle", req_cnt - c0, 1);
    apb_rd(8'h00, d); check("R5 count zero", d, 32'h4700_0000);
    apb_rd(8'h08, d); check("R7 cause expiry", d, 1);
    ticks(3); idle(2);
    check("R5 no repeat at zero", req_cnt - c0, 1);
    apb_rd(8'h00, d); check("R5 no wrap", d, 32'h4700_0000);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    apb_wr(8'h00, 32'h0700_0000, 0);
    apb_wr(8'h04, 32'h0000_000A, 0);
    ticks(3);
    apb_rd(8'h00, d); check("R3 disabled holds", d, 32'h0700_000A);
  endtask

  task automatic t_pause();
    logic [31:0] d;
    apb_wr(8'h00, 32'h4700_0000, 0);
    halt0 = 1; ticks(2); halt0 = 0;
    apb_rd(8'h00, d); check("R4 halt0 gated", d, 32'h4700_000A);
    halt1 = 1; ticks(2); halt1 = 0;
    apb_rd(8'h00, d); check("R4 halt1 gated", d, 32'h4700_000A);
    jtag = 1; ticks(2); jtag = 0;
    apb_rd(8'h00, d); check("R4 jtag gated", d, 32'h4700_000A);
    apb_wr(8'h00, 32'h4000_0000, 0);
    halt0 = 1; halt1 = 1; jtag = 1; ticks(2);
    halt0 = 0; halt1 = 0; jtag = 0;
    apb_rd(8'h00, d); check("R4 ungated halts ignored", d, 32'h4000_0008);
  endtask

  task automatic t_force();
    logic [31:0] d; int c0;
    apb_wr(8'h04, 32'd50, 0);
    apb_wr(8'h00, 32'h4700_0000, 0);
    c0 = req_cnt;
    apb_wr(8'h00, 32'hC700_0000, 0); idle(2);
    check("R6 trigger request", req_cnt - c0, 1);
    apb_rd(8'h00, d); check("R6 trigger clears, bit31 reads 0", d, 32'h4700_0000);
    apb_rd(8'h08, d); check("R7 cause trigger", d, 2);
  endtask

  task automatic t_collide();
    logic [31:0] d; int c0;
    apb_wr(8'h04, 32'd1, 0);
    apb_wr(8'h00, 32'h4000_0000, 0);
    c0 = req_cnt;
    apb_wr(8'h00, 32'hC000_0000, 1); idle(2);
    check("R7 single pulse on collision", req_cnt - c0, 1);
    apb_rd(8'h08, d); check("R7 cause both", d, 3);
    apb_rd(8'h00, d); check("R7 count zero", d, 32'h4000_0000);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    apb_wr(8'h0C, 32'hA5A5_5A5A, 0);
    apb_wr(8'h28, 32'h1234_5678, 0);
    apb_wr(8'h04, 32'd9, 0);
    @(negedge clk); soft_rst_n = 0;
    @(negedge clk); soft_rst_n = 1;
    apb_rd(8'h0C, d); check("R9 scratch0 kept", d, 32'hA5A5_5A5A);
    apb_rd(8'h28, d); check("R9 scratch7 kept", d, 32'h1234_5678);
    apb_rd(8'h00, d); check("R10 ctrl restored", d, 32'h0700_0000);
    apb_rd(8'h08, d); check("R10 cause kept", d, 3);
  endtask

  task automatic t_warm();
    logic [31:0] d;
    @(negedge clk); warm = 1;
    @(negedge clk); warm = 0;
    apb_rd(8'h08, d); check("R8 warm clears cause", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    apb_rd(8'h2C, d); check("R11 unmapped read", d, 0);
    apb_rd(8'h0D, d); check("R11 misaligned read", d, 0);
    check("R11 no error", {30'd0, pready, pslverr}, 32'h2);
    apb_wr(8'h08, 32'h3, 0);
    apb_rd(8'h08, d); check("R11 cause write ignored", d, 0);
    apb_wr(8'h04, 32'h20, 0);
    apb_wr(8'h00, 32'h0700_0055, 0);
    apb_rd(8'h00, d); check("R11 time field write ignored", d, 32'h0700_0020);
  endtask

  task automatic t_hard();
    logic [31:0] d;
    apb_wr(8'h18, 32'hDEAD_BEEF, 0);
    apb_rd(8'h18, d); check("R9 scratch3 write", d, 32'hDEAD_BEEF);
    hard_reset();
    apb_rd(8'h18, d); check("R9 hard reset clears scratch", d, 0);
    apb_rd(8'h00, d); check("R1 ctrl after hard reset", d, 32'h0700_0000);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(1);
    t_reset();
    t_expire();
    t_disabled();
    t_pause();
    t_force();
    t_collide();
    t_soft();
    t_warm();
    t_unmapped();
    t_hard();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule